// File: doc/BRIEF.md
# Multiplexed Byte-Wide Peripheral Bus Controller

This block lets a host run single-byte and short burst transfers to slow 8-bit peripherals over a shared 32-bit multiplexed bus. During a cycle the peripheral address goes out on the low 24 lines and the data byte travels on the top 8 lines. The controller drives an active-low chip enable, a data strobe, and separate read and write enables. Every cycle is stretched by a programmable wait-state code. The bus clock is produced on chip by an integer divider from the core clock, and every bus-side change happens on a rising bus-clock edge.

The host hands over one request at a time through a valid/ready port. A request carries the direction, a 24-bit start address, a burst length of one to four bytes and up to four write bytes. Each cycle has three parts. First comes one address/setup bus clock. Then come the byte transfers, whose address rises by one per byte. Last comes one turnaround bus clock with every output released. At the end of a request a one-cycle done flag is raised, together with the read bytes when the request was a read.

Top module: `pbus_ctrl`

## Requirements
- R1: In a write, every strobe clock drives the byte address on `bus_ad_o[23:0]` and the data byte on `bus_ad_o[31:24]`, with both enables high. Byte i of a burst uses address start+i (modulo 2^24) and write byte `req_wdata[8i+7:8i]`. `req_len` encodes the burst length minus one.
- R2: After reset, and whenever no cycle is active, all four control outputs are high, both drive enables are low, `req_ready` is high and `rsp_done` is low.
- R3: Chip enable is low for exactly 1 + bytes*(1+N) bus clocks, where N is the wait code. The bus clock after that is a turnaround clock with everything released, and it comes before the next request can start.
- R4: In a read, read enable and data strobe are low for 1+N bus clocks per byte, beginning at the second chip-enable clock. Strobes of adjacent bytes are contiguous. The top bus byte is sampled on the last strobe clock of each byte.
- R5: In a write, each byte starts with N bus clocks in which the strobes are high, followed by one clock with write enable and data strobe low. The first strobe falls on chip-enable clock 2+N.
- R6: The wait code (0 to 7) is captured when a request is accepted. Changing it while a cycle is in progress has no effect on that cycle.
- R7: `req_ready` is high only when the controller is idle with no request pending. A `req_valid` raised while busy is ignored and produces no bus activity.
- R8: `rsp_done` is a single core-clock pulse at the end of every request. For reads, `rsp_rdata` then holds byte i in bits [8i+7:8i], and any bytes past the burst length read as zero.
- R9: For a divide value R, the bus clock has a period of R core clocks and stays high for floor(R/2) of them. A value below 2 is treated as 2, so an even R gives a 50% duty cycle.
- R10: Read enable and write enable are never low together, and the top byte lanes are never driven while the read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_ratio | input | DIV_W | Bus clock divide value (below 2 means 2) |
| wait_code | input | 3 | Wait states per byte, captured at accept |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Start peripheral address |
| req_len | input | 2 | Burst length minus one |
| req_wdata | input | 32 | Write bytes, byte i in bits [8i+7:8i] |
| rsp_done | output | 1 | One-cycle end-of-request pulse |
| rsp_rdata | output | 32 | Read bytes, byte i in bits [8i+7:8i] |
| bus_clk | output | 1 | Divided bus clock |
| bus_ad_o | output | 32 | Multiplexed address/data lines out |
| bus_ad_i | input | 32 | Multiplexed lines in (data on 31:24) |
| bus_addr_oe | output | 1 | Drive enable for lines 23:0 |
| bus_data_oe | output | 1 | Drive enable for lines 31:24 |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rd_n | output | 1 | Read enable, active low |
| bus_wr_n | output | 1 | Write enable, active low |

## Verification
The bench builds the block with its default parameters: a 4-bit divider field, a 24-bit address, a four-byte burst limit and a 3-bit wait code. These values let it reach both ends of the wait range (0 and 7), every burst length, and the address wrap at the top of the 24-bit space. The divider field also covers even, odd and below-minimum ratios (0, 2, 3, 4, 5, 6), so the duty-cycle rule and the clamp are both measured. Transfers run at divide values 2 and 3, which shows the sequencer stepping only on bus-clock edges.

// File: rtl/pbus_pkg.sv
// Package: shared types and widths for the multiplexed peripheral bus controller.
// Assumes one core clock domain; the bus clock is derived, never used as a clock.
package pbus_pkg;

    localparam int ADDR_W    = 24;          // peripheral address lines
    localparam int BYTE_W    = 8;           // data lane width
    localparam int BUS_W     = ADDR_W + BYTE_W;
    localparam int BURST_MAX = 4;           // bytes per request at most
    localparam int LEN_W     = $clog2(BURST_MAX);
    localparam int HOST_W    = BYTE_W * BURST_MAX;
    localparam int WAIT_W    = 3;           // wait code 0..7

    // Sequencer phases; each lasts whole bus clocks
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_XFER = 2'd2,
        ST_TURN = 2'd3
    } pbus_state_e;

endpackage

// File: rtl/pbus_clkdiv.sv
// Module: integer divider producing the bus clock and a one-core-cycle tick
// that marks each rising bus-clock edge. Assumes DIV_W >= 2; ratios below 2
// are clamped to 2. High time is floor(ratio/2) core clocks.
module pbus_clkdiv #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] ratio,
    output logic             bclk_o,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_nxt;
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] half;
    logic             bclk_q;

    // Clamp ratio, find the wrap point and the next count
    always_comb begin
        eff     = (ratio < DIV_W'(2)) ? DIV_W'(2) : ratio;
        half    = eff >> 1;
        tick_o  = (cnt_q >= eff - DIV_W'(1));
        cnt_nxt = tick_o ? '0 : cnt_q + DIV_W'(1);
    end

    // Count core clocks and register the bus clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            bclk_q <= (cnt_nxt < half);
        end
    end

    assign bclk_o = bclk_q;

    // R9: every wrap begins a high phase of the bus clock
    assert_tick_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> bclk_o);

endmodule

// File: rtl/pbus_seq.sv
// Module: cycle sequencer. Accepts one host request while idle, then on bus
// clock ticks walks address/setup, per-byte transfers with wait states and a
// turnaround clock. Assumes `tick` is a one-core-cycle pulse per bus clock.
module pbus_seq
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [HOST_W-1:0] req_wdata,
    input  logic [WAIT_W-1:0] wait_code,
    output logic              rsp_done,
    output logic [HOST_W-1:0] rsp_rdata,
    output logic [BUS_W-1:0]  bus_ad_o,
    input  logic [BUS_W-1:0]  bus_ad_i,
    output logic              bus_addr_oe,
    output logic              bus_data_oe,
    output logic              bus_ce_n,
    output logic              bus_ds_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n
);

    localparam int LANE_SH = $clog2(BYTE_W);

    pbus_state_e       state_q;
    logic              pend_q;
    logic              wr_q;
    logic [LEN_W-1:0]  len_q;
    logic [WAIT_W-1:0] wait_q;
    logic [ADDR_W-1:0] base_q;
    logic [HOST_W-1:0] wdata_q;
    logic [LEN_W-1:0]  bidx_q;
    logic [WAIT_W-1:0] ph_q;
    logic [HOST_W-1:0] rdata_q;
    logic              done_q;

    logic              active;
    logic              strobe;
    logic              byte_end;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0] cur_wbyte;
    logic [LEN_W+LANE_SH-1:0] lane_lo;

    // Decode the bus outputs from the registered phase
    always_comb begin
        active    = (state_q == ST_ADDR) || (state_q == ST_XFER);
        strobe    = (state_q == ST_XFER) && (!wr_q || (ph_q == wait_q));
        byte_end  = (state_q == ST_XFER) && (ph_q == wait_q);
        lane_lo   = {bidx_q, {LANE_SH{1'b0}}};
        cur_addr  = base_q + ADDR_W'(bidx_q);
        cur_wbyte = wdata_q[lane_lo +: BYTE_W];
    end

    assign bus_ce_n    = !active;
    assign bus_ds_n    = !strobe;
    assign bus_rd_n    = !(strobe && !wr_q);
    assign bus_wr_n    = !(strobe && wr_q);
    assign bus_addr_oe = active;
    assign bus_data_oe = active && wr_q;
    assign bus_ad_o    = active ? {(wr_q ? cur_wbyte : '0), cur_addr} : '0;
    assign req_ready   = (state_q == ST_IDLE) && !pend_q;
    assign rsp_done    = done_q;
    assign rsp_rdata   = rdata_q;

    // Capture requests and step the cycle on bus clock ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            wr_q    <= 1'b0;
            len_q   <= '0;
            wait_q  <= '0;
            base_q  <= '0;
            wdata_q <= '0;
            bidx_q  <= '0;
            ph_q    <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (req_ready && req_valid) begin
                pend_q  <= 1'b1;
                wr_q    <= req_write;
                len_q   <= req_len;
                wait_q  <= wait_code;
                base_q  <= req_addr;
                wdata_q <= req_wdata;
                rdata_q <= '0;
            end
            if (tick) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (pend_q) begin
                            state_q <= ST_ADDR;
                            pend_q  <= 1'b0;
                            bidx_q  <= '0;
                            ph_q    <= '0;
                        end
                    end
                    ST_ADDR: state_q <= ST_XFER;
                    ST_XFER: begin
                        if (byte_end) begin
                            if (!wr_q) begin
                                rdata_q[lane_lo +: BYTE_W] <= bus_ad_i[BUS_W-1 -: BYTE_W];
                            end
                            ph_q <= '0;
                            if (bidx_q == len_q) begin
                                state_q <= ST_TURN;
                                done_q  <= 1'b1;
                            end else begin
                                bidx_q <= bidx_q + LEN_W'(1);
                            end
                        end else begin
                            ph_q <= ph_q + WAIT_W'(1);
                        end
                    end
                    ST_TURN: state_q <= ST_IDLE;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R3: the done pulse falls in the released turnaround clock
    assert_done_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (bus_ce_n && bus_ds_n && !bus_addr_oe));
    // R4: a strobe only ever falls inside chip enable
    assert_strobe_in_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ds_n |-> !bus_ce_n);
    // R6: the captured wait code holds for the whole cycle
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> $stable(wait_q));
    // R7: readiness only while the bus is released
    assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_ce_n);
    // R8: done lasts a single core cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R10: no drive fight on the data lanes, no double enable
    assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (!bus_data_oe && bus_wr_n));

endmodule

// File: rtl/pbus_ctrl.sv
// Module: top of the multiplexed byte-wide peripheral bus controller.
// Joins the bus clock divider with the cycle sequencer. Assumes the host
// holds request fields stable while req_valid is high.
module pbus_ctrl
    import pbus_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic [WAIT_W-1:0] wait_code,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [HOST_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [HOST_W-1:0] rsp_rdata,
    output logic              bus_clk,
    output logic [BUS_W-1:0]  bus_ad_o,
    input  logic [BUS_W-1:0]  bus_ad_i,
    output logic              bus_addr_oe,
    output logic              bus_data_oe,
    output logic              bus_ce_n,
    output logic              bus_ds_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n
);

    logic tick;

    pbus_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .ratio  (div_ratio),
        .bclk_o (bus_clk),
        .tick_o (tick)
    );

    pbus_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .req_wdata   (req_wdata),
        .wait_code   (wait_code),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata),
        .bus_ad_o    (bus_ad_o),
        .bus_ad_i    (bus_ad_i),
        .bus_addr_oe (bus_addr_oe),
        .bus_data_oe (bus_data_oe),
        .bus_ce_n    (bus_ce_n),
        .bus_ds_n    (bus_ds_n),
        .bus_rd_n    (bus_rd_n),
        .bus_wr_n    (bus_wr_n)
    );

endmodule

// File: tb/tb_pbus_ctrl.sv
// Scoreboard bench: the driver task queues expected beats and request
// summaries; a monitor samples once per bus clock and pops and compares them.
module tb_pbus_ctrl;

    localparam int DIV_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [DIV_W-1:0] div_ratio;
    logic [2:0]  wait_code;
    logic        req_valid, req_ready, req_write;
    logic [23:0] req_addr;
    logic [1:0]  req_len;
    logic [31:0] req_wdata;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        bus_clk;
    logic [31:0] bus_ad_o, bus_ad_i;
    logic        bus_addr_oe, bus_data_oe, bus_ce_n, bus_ds_n, bus_rd_n, bus_wr_n;

    always #5 clk = ~clk;

    pbus_ctrl #(.DIV_W(DIV_W)) dut (.*);

    // Peripheral model: a read returns a byte derived from the address
    function automatic logic [7:0] periph(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    assign bus_ad_i = {(bus_rd_n ? 8'hFF : periph(bus_ad_o[23:0])), 24'h0};

    typedef struct {
        bit          wr;
        int          n;
        int          w;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t        rq[$];
    logic [31:0] wq[$];
    int checks = 0, errors = 0, issued = 0, done_seen = 0;
    int cepos = 0, strb = 0, first = 0;
    logic pb = 1'b0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: one sample per bus clock plus the done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_clk && !pb) begin
                if (!bus_ce_n) begin
                    cepos++;
                    if (!bus_ds_n) begin
                        strb++;
                        if (first == 0) first = cepos;
                        if (!bus_wr_n) begin
                            if (wq.size() == 0) chk("R7 unexpected write beat", 1, 0);
                            else begin
                                logic [31:0] e;
                                e = wq.pop_front();
                                chk("R1 write address lines", bus_ad_o[23:0], e[23:0]);
                                chk("R1 write data lines", bus_ad_o[31:24], e[31:24]);
                                chk("R1 drive enables", {bus_addr_oe, bus_data_oe}, 2'b11);
                            end
                        end else begin
                            chk("R10 data lanes released in read", bus_data_oe, 0);
                        end
                    end
                end else begin
                    chk("R2 released when idle", {bus_addr_oe, bus_data_oe, bus_ds_n, bus_rd_n, bus_wr_n}, 5'b00111);
                end
            end
            pb = bus_clk;
            if (rsp_done) begin
                done_seen++;
                chk("R3 turnaround at done", {bus_ce_n, bus_addr_oe}, 2'b10);
                if (rq.size() == 0) chk("R7 unexpected done", 1, 0);
                else begin
                    exp_t e;
                    e = rq.pop_front();
                    chk({"R3 ce clocks ", e.tag}, cepos, 1 + e.n * (1 + e.w));
                    if (e.wr) begin
                        chk({"R5 strobe clocks ", e.tag}, strb, e.n);
                        chk({"R5 first strobe position ", e.tag}, first, 2 + e.w);
                    end else begin
                        chk({"R4 strobe clocks ", e.tag}, strb, e.n * (1 + e.w));
                        chk({"R4 first strobe position ", e.tag}, first, 2);
                        chk({"R8 read data ", e.tag}, rsp_rdata, e.rd);
                    end
                end
                cepos = 0; strb = 0; first = 0;
            end
        end
    end

    // Driver: queue expectations, issue one request, optionally disturb it
    task automatic run_req(input bit wr, input logic [23:0] a, input int n,
                           input logic [31:0] wd, input int w, input int mode,
                           input string tag);
        exp_t e;
        int target;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.wr = wr; e.n = n; e.w = w; e.rd = '0; e.tag = tag;
        for (int i = 0; i < n; i++) begin
            logic [23:0] ai;
            ai = a + 24'(i);
            if (wr) wq.push_back({wd[8*i +: 8], ai});
            else e.rd[8*i +: 8] = periph(ai);
        end
        rq.push_back(e);
        issued++;
        target = issued;
        req_write = wr; req_addr = a; req_len = 2'(n - 1);
        req_wdata = wd; wait_code = 3'(w); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (mode == 1) begin
            repeat (5) @(negedge clk);
            chk("R7 ready low while busy", req_ready, 0);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 24'h123456;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end else if (mode == 2) begin
            repeat (5) @(negedge clk);
            wait_code = 3'd0;
        end
        while (done_seen < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Divider: measure high and low time of one bus clock period
    task automatic meas(input int r);
        int hi, lo, eff;
        div_ratio = DIV_W'(r);
        repeat (40) @(negedge clk);
        while (bus_clk) @(negedge clk);
        while (!bus_clk) @(negedge clk);
        hi = 0;
        while (bus_clk) begin hi++; @(negedge clk); end
        lo = 0;
        while (!bus_clk) begin lo++; @(negedge clk); end
        eff = (r < 2) ? 2 : r;
        chk($sformatf("R9 high time ratio %0d", r), hi, eff / 2);
        chk($sformatf("R9 low time ratio %0d", r), lo, eff - eff / 2);
    endtask

    initial begin
        div_ratio = DIV_W'(2); wait_code = '0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_len = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset controls", {bus_ce_n, bus_ds_n, bus_rd_n, bus_wr_n}, 4'hF);
        chk("R2 reset enables", {bus_addr_oe, bus_data_oe}, 2'b00);
        chk("R2 reset ready/done", {req_ready, rsp_done}, 2'b10);

        meas(4); meas(6); meas(5); meas(0); meas(2);

        run_req(0, 24'h000010, 1, 32'h0, 0, 0, "rd1 w0");
        run_req(0, 24'h0A0B0C, 4, 32'h0, 0, 0, "rd4 w0");
        run_req(0, 24'h00F0F0, 2, 32'h0, 3, 0, "rd2 w3");
        run_req(0, 24'h123400, 3, 32'h0, 7, 0, "rd3 w7");
        run_req(1, 24'h000020, 1, 32'h000000A5, 0, 0, "wr1 w0");
        run_req(1, 24'h445566, 4, 32'hDEADBEEF, 0, 0, "wr4 w0");
        run_req(1, 24'h00ABCD, 2, 32'h00005A3C, 2, 0, "wr2 w2");
        run_req(1, 24'h777777, 4, 32'h01234567, 5, 0, "wr4 w5");
        run_req(0, 24'hFFFFFE, 4, 32'h0, 1, 0, "R1 address wrap");
        div_ratio = DIV_W'(3);
        run_req(0, 24'h003300, 2, 32'h0, 2, 0, "ratio 3");
        div_ratio = DIV_W'(2);
        run_req(1, 24'h0C0C0C, 2, 32'h0000C3E1, 4, 1, "R7 busy request");
        run_req(0, 24'h00BEEF, 2, 32'h0, 4, 2, "R6 wait change");
        run_req(1, 24'h00BEF0, 3, 32'h00112233, 6, 2, "R6 wait change wr");

        chk("R8 done count", done_seen, issued);
        chk("R7 no leftover beats", wq.size() + rq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule